// File: doc/BRIEF.md
# Dual-Slot Instruction Bundle Sequencer

This block sits between instruction fetch and an execute stage. It accepts one 32-bit bundle at a time and sorts it by the two-bit header in bits [31:30]. The bundle is either a single 30-bit long operation or a pair of 15-bit short operations. It then presents the operations one at a time as issue slots. Each slot carries the raw operation bits, a six-bit index for the decode-table lookup, a long/short flag and the side (left or right) the operation came from. The slot stays on the outputs until the execute stage reports it done. With that report come three feedback bits: whether the operation changed the program counter, whether it raised an exception, and the result of a condition test.

Short pairs run in one of three ways. In the two sequential orders, a branch or an exception in the first operation cancels the second. In parallel issue, a plain pair runs left then right. A pair in which one side is a test-only operation runs that side first, and its partner runs only when the condition comes back true.

The decode lookup supplies the test-only markings for the two halves. They arrive with the bundle on `testLeft` and `testRight`. The block also keeps a set of saturating event counters. A synchronous clear input zeroes all of them.

Top module: `bundle_issue_seq`

## Requirements
- R1: After reset `wordReady` is 1, `slotValid` is 0 and every counter reads 0.
- R2: A bundle is accepted on a clock edge where `wordValid` and `wordReady` are both 1, and its first slot is valid in the next cycle. Header 00 issues one slot with `slotLong`=1, `slotBits` = bundle bits [29:0] and `slotHash` = bundle bits [29:24]. After that slot is done the block returns to ready.
- R3: While `slotValid` is 1 and `execDone` is 0, the slot outputs hold steady.
- R4: The left operation is bundle bits [29:15] and the right operation is bits [14:0]. `slotSide` is 0 for left and 1 for right. A short slot gives the field in `slotBits` [14:0] with zeros above it, and field bits [14:9] in `slotHash`. Header 10 issues left then right. Header 01 issues right then left.
- R5: In the sequential headers (01, 10), the second operation is skipped if the first reports a PC change or an exception. The branch-skip counter counts a PC change that comes without an exception.
- R6: Header 11 with neither half marked test-only issues left then right. An exception on the left slot cancels the right slot.
- R7: Header 11 with a test-only half issues that half first. The left half wins if both are marked. A false condition counts in the false counter and ends the bundle. A true condition without an exception counts in the true counter and issues the partner.
- R8: The cycle counter adds 1 for every accepted bundle and 1 more whenever a sequential second operation issues.
- R9: The long, parallel, left-then-right and right-then-left counters each add 1 per accepted bundle with header 00, 11, 10 and 01 respectively.
- R10: Counters saturate at all ones and never wrap.
- R11: `cntClear` zeroes every counter on the next edge and takes priority over any increment in the same cycle.
- R12: An exception reported on any slot ends the bundle, so the block is ready in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wordValid | input | 1 | A bundle is offered |
| wordIn | input | 32 | Bundle word, header in [31:30] |
| testLeft | input | 1 | Left half is a test-only operation |
| testRight | input | 1 | Right half is a test-only operation |
| wordReady | output | 1 | Block idle, next bundle may be accepted |
| slotValid | output | 1 | An issue slot is presented |
| slotBits | output | 30 | Raw operation bits of the slot |
| slotHash | output | 6 | Decode-table index of the slot |
| slotLong | output | 1 | Slot is a long operation |
| slotSide | output | 1 | 0 left half, 1 right half |
| execDone | input | 1 | Execute stage retires the current slot |
| execPcChanged | input | 1 | Retired slot changed the PC |
| execExcept | input | 1 | Retired slot raised an exception |
| execCond | input | 1 | Condition produced by a test-only slot |
| cntClear | input | 1 | Synchronous clear of all counters |
| cntCycles | output | CNT_W | Issue-cycle counter |
| cntLong | output | CNT_W | Long bundles |
| cntParallel | output | CNT_W | Parallel bundles |
| cntLeftRight | output | CNT_W | Left-then-right bundles |
| cntRightLeft | output | CNT_W | Right-then-left bundles |
| cntCondTrue | output | CNT_W | Partners issued on a true condition |
| cntCondFalse | output | CNT_W | Partners dropped on a false condition |
| cntBranchSkip | output | CNT_W | Second operations skipped by a branch |

## Verification
The sweep covers every combination of the four headers, both test-only markings and the three feedback bits on the first slot. That is enough to separate:
- the two sequential orders from each other and from parallel issue;
- branch suppression from exception suppression;
- left priority when both halves are marked test-only.

The bundle bits are a scrambled pattern, so a swapped half or a misplaced hash field shows up in the slot outputs. One clear is issued in the same cycle as an accepted bundle, which shows whether clear beats increment. A long run of bundles then drives the narrow bench counters to all ones, which shows whether they saturate or wrap.

// File: rtl/bundle_seq_pkg.sv
package bundle_seq_pkg;

  localparam int WORD_W   = 32;
  localparam int OP_W     = 30;
  localparam int SHORT_W  = 15;
  localparam int HASH_W   = 6;
  localparam int LONG_HASH_LSB  = OP_W - HASH_W;
  localparam int SHORT_HASH_LSB = SHORT_W - HASH_W;

  // counter indices
  localparam int CNT_CYC   = 0;
  localparam int CNT_LONG  = 1;
  localparam int CNT_PAR   = 2;
  localparam int CNT_LR    = 3;
  localparam int CNT_RL    = 4;
  localparam int CNT_TRUE  = 5;
  localparam int CNT_FALSE = 6;
  localparam int CNT_SKIP  = 7;
  localparam int NUM_CNT   = 8;

  typedef enum logic [1:0] {
    MODE_LONG = 2'b00,
    MODE_RL   = 2'b01,
    MODE_LR   = 2'b10,
    MODE_PAR  = 2'b11
  } bundleMode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } seqState_e;

  typedef struct packed {
    logic               load;
    logic               selRight;
    logic               selLong;
    logic [NUM_CNT-1:0] inc;
  } seqStrobe_t;

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import bundle_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wordValid,
  input  logic [1:0] modeIn,
  input  logic       testL,
  input  logic       testR,
  input  logic       execDone,
  input  logic       pcChg,
  input  logic       exc,
  input  logic       cond,
  output logic       wordReady,
  output logic       slotValid,
  output seqStrobe_t strobe
);

  seqState_e   state, nextSt;
  bundleMode_e mode, nextMode;
  logic        firstRight, nextFirstRight;
  logic        condMode, nextCondMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      mode       <= MODE_LONG;
      firstRight <= 1'b0;
      condMode   <= 1'b0;
    end else begin
      state      <= nextSt;
      mode       <= nextMode;
      firstRight <= nextFirstRight;
      condMode   <= nextCondMode;
    end
  end

  always_comb begin
    strobe         = '0;
    nextSt         = state;
    nextMode       = mode;
    nextFirstRight = firstRight;
    nextCondMode   = condMode;
    wordReady      = (state == ST_IDLE);
    slotValid      = (state != ST_IDLE);
    strobe.selLong  = (mode == MODE_LONG);
    strobe.selRight = (state == ST_SECOND) ? ~firstRight : firstRight;

    case (state)
      ST_IDLE: begin
        if (wordValid) begin
          strobe.load = 1'b1;
          strobe.inc[CNT_CYC] = 1'b1;
          case (bundleMode_e'(modeIn))
            MODE_LONG: strobe.inc[CNT_LONG] = 1'b1;
            MODE_RL:   strobe.inc[CNT_RL]   = 1'b1;
            MODE_LR:   strobe.inc[CNT_LR]   = 1'b1;
            default:   strobe.inc[CNT_PAR]  = 1'b1;
          endcase
          nextMode       = bundleMode_e'(modeIn);
          // test-only half goes first, left has priority
          nextFirstRight = (modeIn == MODE_RL) ||
                           ((modeIn == MODE_PAR) && !testL && testR);
          nextCondMode   = (modeIn == MODE_PAR) && (testL || testR);
          nextSt         = ST_FIRST;
        end
      end

      ST_FIRST: begin
        if (execDone) begin
          nextSt = ST_IDLE;
          case (mode)
            MODE_LONG: ;
            MODE_RL, MODE_LR: begin
              if (!pcChg && !exc) begin
                nextSt = ST_SECOND;
                strobe.inc[CNT_CYC] = 1'b1;
              end else if (pcChg && !exc) begin
                strobe.inc[CNT_SKIP] = 1'b1;
              end
            end
            default: begin
              if (condMode) begin
                if (!cond) begin
                  strobe.inc[CNT_FALSE] = 1'b1;
                end else if (!exc) begin
                  strobe.inc[CNT_TRUE] = 1'b1;
                  nextSt = ST_SECOND;
                end
              end else if (!exc) begin
                nextSt = ST_SECOND;
              end
            end
          endcase
        end
      end

      ST_SECOND: begin
        if (execDone) nextSt = ST_IDLE;
      end

      default: nextSt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/seq_dp.sv
module seq_dp
  import bundle_seq_pkg::*;
#(
  parameter int CNT_W = 32
)(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [OP_W-1:0]                 opIn,
  input  seqStrobe_t                      strobe,
  input  logic                            cntClear,
  output logic [OP_W-1:0]                 slotBits,
  output logic [HASH_W-1:0]               slotHash,
  output logic [NUM_CNT-1:0][CNT_W-1:0]   cntAll
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int PAD_W = OP_W - SHORT_W;

  logic [OP_W-1:0]    opReg;
  logic [SHORT_W-1:0] field;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            opReg <= '0;
    else if (strobe.load) opReg <= opIn;
  end

  always_comb begin
    field = strobe.selRight ? opReg[SHORT_W-1:0] : opReg[OP_W-1:SHORT_W];
    if (strobe.selLong) begin
      slotBits = opReg;
      slotHash = opReg[LONG_HASH_LSB +: HASH_W];
    end else begin
      slotBits = {{PAD_W{1'b0}}, field};
      slotHash = field[SHORT_HASH_LSB +: HASH_W];
    end
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : gCnt
    logic [CNT_W-1:0] val;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                 val <= '0;
      else if (cntClear)                         val <= '0;
      else if (strobe.inc[i] && val != CNT_MAX)  val <= val + 1'b1;
    end
    assign cntAll[i] = val;
  end

endmodule

// File: rtl/bundle_issue_seq.sv
module bundle_issue_seq
  import bundle_seq_pkg::*;
#(
  parameter int CNT_W = 32
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wordValid,
  input  logic [31:0]        wordIn,
  input  logic               testLeft,
  input  logic               testRight,
  output logic               wordReady,
  output logic               slotValid,
  output logic [29:0]        slotBits,
  output logic [5:0]         slotHash,
  output logic               slotLong,
  output logic               slotSide,
  input  logic               execDone,
  input  logic               execPcChanged,
  input  logic               execExcept,
  input  logic               execCond,
  input  logic               cntClear,
  output logic [CNT_W-1:0]   cntCycles,
  output logic [CNT_W-1:0]   cntLong,
  output logic [CNT_W-1:0]   cntParallel,
  output logic [CNT_W-1:0]   cntLeftRight,
  output logic [CNT_W-1:0]   cntRightLeft,
  output logic [CNT_W-1:0]   cntCondTrue,
  output logic [CNT_W-1:0]   cntCondFalse,
  output logic [CNT_W-1:0]   cntBranchSkip
);

  seqStrobe_t                    strobe;
  logic [NUM_CNT-1:0][CNT_W-1:0] cntAll;

  seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wordValid (wordValid),
    .modeIn    (wordIn[WORD_W-1:OP_W]),
    .testL     (testLeft),
    .testR     (testRight),
    .execDone  (execDone),
    .pcChg     (execPcChanged),
    .exc       (execExcept),
    .cond      (execCond),
    .wordReady (wordReady),
    .slotValid (slotValid),
    .strobe    (strobe)
  );

  seq_dp #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .opIn     (wordIn[OP_W-1:0]),
    .strobe   (strobe),
    .cntClear (cntClear),
    .slotBits (slotBits),
    .slotHash (slotHash),
    .cntAll   (cntAll)
  );

  assign slotLong      = strobe.selLong;
  assign slotSide      = strobe.selRight;
  assign cntCycles     = cntAll[CNT_CYC];
  assign cntLong       = cntAll[CNT_LONG];
  assign cntParallel   = cntAll[CNT_PAR];
  assign cntLeftRight  = cntAll[CNT_LR];
  assign cntRightLeft  = cntAll[CNT_RL];
  assign cntCondTrue   = cntAll[CNT_TRUE];
  assign cntCondFalse  = cntAll[CNT_FALSE];
  assign cntBranchSkip = cntAll[CNT_SKIP];

endmodule

// File: rtl/bundle_issue_seq_chk.sv
module bundle_issue_seq_chk #(
  parameter int CNT_W = 32
)(
  input logic             clk,
  input logic             rstN,
  input logic             wordValid,
  input logic             wordReady,
  input logic             slotValid,
  input logic [29:0]      slotBits,
  input logic             slotSide,
  input logic             slotLong,
  input logic             execDone,
  input logic             execExcept,
  input logic             cntClear,
  input logic [CNT_W-1:0] cntCycles,
  input logic [CNT_W-1:0] cntLong,
  input logic [CNT_W-1:0] cntBranchSkip
);

  a_r2_accept_issues: assert property (@(posedge clk) disable iff (!rstN)
    wordValid && wordReady |=> slotValid);

  a_r2_long_single: assert property (@(posedge clk) disable iff (!rstN)
    slotValid && slotLong && execDone |=> wordReady && !slotValid);

  a_r3_slot_hold: assert property (@(posedge clk) disable iff (!rstN)
    slotValid && !execDone |=> slotValid && $stable(slotBits) && $stable(slotSide));

  a_r12_exc_ends: assert property (@(posedge clk) disable iff (!rstN)
    slotValid && execDone && execExcept |=> wordReady);

  a_r8_no_decrease: assert property (@(posedge clk) disable iff (!rstN)
    !cntClear |=> cntCycles >= $past(cntCycles));

  a_r10_saturate: assert property (@(posedge clk) disable iff (!rstN)
    !cntClear && (cntCycles == {CNT_W{1'b1}}) |=> cntCycles == {CNT_W{1'b1}});

  a_r11_clear: assert property (@(posedge clk) disable iff (!rstN)
    cntClear |=> cntCycles == '0 && cntLong == '0 && cntBranchSkip == '0);

endmodule

bind bundle_issue_seq bundle_issue_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .wordValid     (wordValid),
  .wordReady     (wordReady),
  .slotValid     (slotValid),
  .slotBits      (slotBits),
  .slotSide      (slotSide),
  .slotLong      (slotLong),
  .execDone      (execDone),
  .execExcept    (execExcept),
  .cntClear      (cntClear),
  .cntCycles     (cntCycles),
  .cntLong       (cntLong),
  .cntBranchSkip (cntBranchSkip)
);

// File: tb/bundle_issue_seq_tb.sv
module bundle_issue_seq_tb;

  localparam int CW = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wordValid = 1'b0;
  logic [31:0]   wordIn = '0;
  logic          testLeft = 1'b0, testRight = 1'b0;
  logic          wordReady, slotValid, slotLong, slotSide;
  logic [29:0]   slotBits;
  logic [5:0]    slotHash;
  logic          execDone = 1'b0, execPcChanged = 1'b0, execExcept = 1'b0, execCond = 1'b0;
  logic          cntClear = 1'b0;
  logic [CW-1:0] cntCycles, cntLong, cntParallel, cntLeftRight, cntRightLeft;
  logic [CW-1:0] cntCondTrue, cntCondFalse, cntBranchSkip;

  int checks = 0;
  int fails = 0;
  int model [8];
  logic [31:0] curWord;

  always #2.5 clk = ~clk;

  bundle_issue_seq #(.CNT_W(CW)) u_dut (.*);

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic void bump(input int idx);
    if (model[idx] < CMAX) model[idx]++;
  endfunction

  task automatic expectSlot(input logic right, input logic isLong, input string tag);
    logic [14:0] f;
    logic [29:0] eb;
    logic [5:0]  eh;
    f  = right ? curWord[14:0] : curWord[29:15];
    eb = isLong ? curWord[29:0] : {15'b0, f};
    eh = isLong ? curWord[29:24] : f[14:9];
    chk(slotValid == 1'b1, tag, slotValid, 1);
    chk(slotLong == isLong, tag, slotLong, isLong);
    if (!isLong) chk(slotSide == right, tag, slotSide, right);
    chk(slotBits == eb, tag, slotBits, eb);
    chk(slotHash == eh, tag, slotHash, eh);
  endtask

  task automatic retire(input logic pc, input logic ex, input logic cd);
    execDone = 1'b1; execPcChanged = pc; execExcept = ex; execCond = cd;
    @(negedge clk);
    execDone = 1'b0; execPcChanged = 1'b0; execExcept = 1'b0; execCond = 1'b0;
  endtask

  task automatic chkCounters();
    chk(cntCycles     == model[0], "R8 cycles",    cntCycles,     model[0]);
    chk(cntLong       == model[1], "R9 long",      cntLong,       model[1]);
    chk(cntParallel   == model[2], "R9 parallel",  cntParallel,   model[2]);
    chk(cntLeftRight  == model[3], "R9 lr",        cntLeftRight,  model[3]);
    chk(cntRightLeft  == model[4], "R9 rl",        cntRightLeft,  model[4]);
    chk(cntCondTrue   == model[5], "R7 true",      cntCondTrue,   model[5]);
    chk(cntCondFalse  == model[6], "R7 false",     cntCondFalse,  model[6]);
    chk(cntBranchSkip == model[7], "R5 skip",      cntBranchSkip, model[7]);
  endtask

  task automatic runBundle(input logic [31:0] w, input logic tL, input logic tR,
                           input logic pc, input logic ex, input logic cd,
                           input logic clr, input logic fullCheck);
    logic [1:0] mode;
    logic firstR, second, isLong;
    string tag;
    mode = w[31:30];
    curWord = w;
    @(negedge clk);
    chk(wordReady == 1'b1, "R2 ready before accept", wordReady, 1);
    wordIn = w; wordValid = 1'b1; testLeft = tL; testRight = tR; cntClear = clr;
    @(negedge clk);
    wordValid = 1'b0; cntClear = 1'b0;
    if (clr) begin
      for (int i = 0; i < 8; i++) model[i] = 0;
      chk(cntCycles == 0 && cntLong == 0, "R11 clear wins", cntCycles, 0);
    end else begin
      bump(0);
      case (mode)
        2'b00: bump(1);
        2'b01: bump(4);
        2'b10: bump(3);
        default: bump(2);
      endcase
    end
    isLong = (mode == 2'b00);
    firstR = (mode == 2'b01) || (mode == 2'b11 && !tL && tR);
    second = 1'b0;
    case (mode)
      2'b00: tag = "R2 long slot";
      2'b01, 2'b10: begin
        tag = "R4 sequential order";
        second = !pc && !ex;
        if (second) bump(0);
        else if (pc && !ex) bump(7);
      end
      default: begin
        if (tL || tR) begin
          tag = "R7 test slot first";
          if (!cd) bump(6);
          else if (!ex) begin bump(5); second = 1'b1; end
        end else begin
          tag = "R6 parallel order";
          second = !ex;
        end
      end
    endcase
    expectSlot(firstR, isLong, tag);
    if (fullCheck) begin
      @(negedge clk);
      expectSlot(firstR, isLong, "R3 hold");
    end
    retire(pc, ex, cd);
    if (second) begin
      expectSlot(!firstR, 1'b0, {tag, " second"});
      retire(1'b0, 1'b0, 1'b0);
    end
    if (fullCheck) begin
      chk(slotValid == 1'b0, ex ? "R12 exception ends" : "R5 bundle end", slotValid, 0);
      chk(wordReady == 1'b1, "R5 ready after bundle", wordReady, 1);
      chkCounters();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(wordReady == 1'b1, "R1 ready", wordReady, 1);
    chk(slotValid == 1'b0, "R1 no slot", slotValid, 0);
    chkCounters();

    // sweep headers, test marks and feedback of the first slot
    for (int k = 0; k < 128; k++) begin
      logic [29:0] pat;
      pat = 30'(32'h2545F491 * (k + 1) + 32'h3A5C_0F17);
      runBundle({k[6:5], pat}, k[4], k[3], k[2], k[1], k[0], 1'b0, 1'b1);
    end

    // R11: clear together with an accepted bundle
    runBundle({2'b00, 30'h1234_5678}, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);

    // R10: drive counters past all ones
    for (int k = 0; k < 262; k++)
      runBundle({2'b00, 30'(k * 977)}, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk(cntLong == CW'(CMAX), "R10 long saturates", cntLong, CMAX);
    chk(cntCycles == CW'(CMAX), "R10 cycles saturate", cntCycles, CMAX);
    chkCounters();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule